// File: doc/BRIEF.md
# MII PHY-Side Port Controller

This block sits on the physical-layer side of a Clause 22 style media independent interface. It takes the transmit nibble, its strobe and its error flag from the MAC and hands them on toward the line coder as a code group. It takes code groups from the line decoder and presents them to the MAC as a receive nibble with a valid strobe and an error flag. From the transmit and receive activity it also produces carrier sense and collision for the MAC.

Three configuration inputs choose line speed, full or half duplex, and a raw code-group mode. In raw mode at 100 Mb/s the MAC exchanges unencoded 5-bit code groups. The low four bits use the nibble lines and the top bit uses the error lines. At 10 Mb/s the path is always four bits wide and the raw setting changes nothing. A new setting is adopted only when both directions have been idle for a full cycle, so a frame in flight is never corrupted. Both MII directions are assumed to be clocked from one external clock. Its rate (25 MHz or 2.5 MHz) is set outside the block.

Top module: `mii_phy_port`

## Requirements
- R1: In nibble mode, one cycle after a rising clock edge, `line_tx_grp` is {0, `mac_tx_nib`} while `mac_tx_strobe` was high and 0 otherwise. `line_tx_vld` equals the sampled strobe, and `line_tx_bad` equals the sampled `mac_tx_fault` AND strobe.
- R2: In raw mode at 100 Mb/s, bit 4 of `line_tx_grp` carries the sampled `mac_tx_fault` during strobe, and `line_tx_bad` stays 0.
- R3: In nibble mode, one cycle after an edge, `mac_rx_nib` is `line_rx_grp[3:0]` while `line_rx_vld` was high and 0 otherwise. `mac_rx_strobe` equals the sampled `line_rx_vld`, and `mac_rx_fault` equals the sampled `line_rx_bad`.
- R4: In raw mode at 100 Mb/s, `mac_rx_fault` carries `line_rx_grp[4]` AND `line_rx_vld`, and `line_rx_bad` has no effect on it.
- R5: At 10 Mb/s the raw setting has no effect, and both directions behave as in R1 and R3.
- R6: In half duplex, `mac_collide` is high exactly in the cycles where both `line_tx_vld` and `mac_rx_strobe` are high.
- R7: In full duplex, `mac_collide` stays 0.
- R8: In half duplex, `mac_carrier` is high exactly when `line_tx_vld` or `mac_rx_strobe` is high.
- R9: In full duplex, `mac_carrier` follows `mac_rx_strobe` only.
- R10: A change of speed, duplex or raw setting made while either direction is active takes effect only after an edge at which both inputs and both registered activity flags were idle.
- R11: During and after synchronous reset, all data, strobe, error, carrier and collision outputs are 0. The configuration inputs present at reset become active at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII clock shared by both directions |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fast | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| cfg_fdx | input | 1 | 1 selects full duplex |
| cfg_raw | input | 1 | 1 requests raw 5-bit code-group mode |
| mac_tx_nib | input | 4 | Transmit nibble from the MAC |
| mac_tx_strobe | input | 1 | Transmit data present |
| mac_tx_fault | input | 1 | Transmit error, or code bit 4 in raw mode |
| line_tx_grp | output | 5 | Code group toward the line coder |
| line_tx_vld | output | 1 | Transmit group valid (transmit activity) |
| line_tx_bad | output | 1 | Transmit error toward the coder |
| line_rx_grp | input | 5 | Code group from the line decoder |
| line_rx_vld | input | 1 | Receive group valid |
| line_rx_bad | input | 1 | Receive coding error from the decoder |
| mac_rx_nib | output | 4 | Receive nibble to the MAC |
| mac_rx_strobe | output | 1 | Receive data valid (receive activity) |
| mac_rx_fault | output | 1 | Receive error, or code bit 4 in raw mode |
| mac_carrier | output | 1 | Carrier sense |
| mac_collide | output | 1 | Collision |

## Verification
On every cycle, the assertions hold the duplex rules for collision and carrier against the registered activity outputs. They also check that collision never appears in full duplex, that the transmit error is silenced in raw mode, and that the active configuration stays frozen while a direction is busy. Only the bench scenarios show the exact data mapping for every nibble and code-group value under all eight configurations. The same holds for the deferred adoption of a setting changed mid-frame, which the bench observes through the collision and error outputs.

// File: rtl/mii_port_pkg.sv
package mii_port_pkg;
  localparam int NIB_W = 4;
  localparam int GRP_W = NIB_W + 1;

  typedef struct packed {
    logic fast;
    logic fdx;
    logic raw;
  } port_mode_t;
endpackage

// File: rtl/mii_mode_gate.sv
module mii_mode_gate
  import mii_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  port_mode_t req_i,
  input  logic       tx_live_i,
  input  logic       rx_live_i,
  input  logic       tx_busy_i,
  input  logic       rx_busy_i,
  output port_mode_t cur_o
);
  logic quiet;
  assign quiet = !(tx_live_i || rx_live_i || tx_busy_i || rx_busy_i);

  always_ff @(posedge clk) begin
    if (rst)        cur_o <= req_i;
    else if (quiet) cur_o <= req_i;
  end

  // R10: a busy direction freezes the active mode
  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_busy_i || rx_busy_i || tx_live_i || rx_live_i) |=> $stable(cur_o));
endmodule

// File: rtl/mii_tx_lane.sv
module mii_tx_lane #(
  parameter int NIB_W = 4,
  localparam int GRP_W = NIB_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             strobe_i,
  input  logic             fault_i,
  output logic [GRP_W-1:0] grp_o,
  output logic             vld_o,
  output logic             bad_o
);
  logic top_bit;
  assign top_bit = raw_i ? fault_i : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_o <= '0;
      vld_o <= 1'b0;
      bad_o <= 1'b0;
    end else begin
      vld_o <= strobe_i;
      grp_o <= strobe_i ? {top_bit, nib_i} : '0;
      bad_o <= strobe_i && fault_i && !raw_i;
    end
  end

  // R2: raw mode never reports a transmit error
  p_raw_no_err_r2: assert property (@(posedge clk) disable iff (rst)
    raw_i |=> !bad_o);
  // R1: idle input leaves an empty group
  p_idle_empty_r1: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> (grp_o == '0) && !vld_o);
endmodule

// File: rtl/mii_rx_lane.sv
module mii_rx_lane #(
  parameter int NIB_W = 4,
  localparam int GRP_W = NIB_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic             vld_i,
  input  logic             bad_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             strobe_o,
  output logic             fault_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nib_o    <= '0;
      strobe_o <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      strobe_o <= vld_i;
      nib_o    <= vld_i ? grp_i[NIB_W-1:0] : '0;
      fault_o  <= raw_i ? (grp_i[NIB_W] && vld_i) : bad_i;
    end
  end

  // R4: in raw mode an idle receiver reports no error bit
  p_raw_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (raw_i && !vld_i) |=> !fault_o);
endmodule

// File: rtl/mii_sense.sv
module mii_sense (
  input  logic clk,
  input  logic rst,
  input  logic fdx_i,
  input  logic tx_live_i,
  input  logic rx_live_i,
  output logic carrier_o,
  output logic collide_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      carrier_o <= 1'b0;
      collide_o <= 1'b0;
    end else begin
      carrier_o <= rx_live_i || (!fdx_i && tx_live_i);
      collide_o <= !fdx_i && tx_live_i && rx_live_i;
    end
  end

  // R7: collision only outside full duplex
  p_no_col_fdx_r7: assert property (@(posedge clk) disable iff (rst)
    collide_o |-> !fdx_i);
endmodule

// File: rtl/mii_phy_port.sv
module mii_phy_port
  import mii_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_fast,
  input  logic             cfg_fdx,
  input  logic             cfg_raw,
  input  logic [NIB_W-1:0] mac_tx_nib,
  input  logic             mac_tx_strobe,
  input  logic             mac_tx_fault,
  output logic [GRP_W-1:0] line_tx_grp,
  output logic             line_tx_vld,
  output logic             line_tx_bad,
  input  logic [GRP_W-1:0] line_rx_grp,
  input  logic             line_rx_vld,
  input  logic             line_rx_bad,
  output logic [NIB_W-1:0] mac_rx_nib,
  output logic             mac_rx_strobe,
  output logic             mac_rx_fault,
  output logic             mac_carrier,
  output logic             mac_collide
);
  port_mode_t req, cur;
  logic raw_eff;

  assign req = '{fast: cfg_fast, fdx: cfg_fdx, raw: cfg_raw};
  // R5: raw code groups exist only at 100 Mb/s
  assign raw_eff = cur.raw && cur.fast;

  mii_mode_gate u_gate (
    .clk(clk), .rst(rst), .req_i(req),
    .tx_live_i(mac_tx_strobe), .rx_live_i(line_rx_vld),
    .tx_busy_i(line_tx_vld), .rx_busy_i(mac_rx_strobe),
    .cur_o(cur)
  );

  mii_tx_lane #(.NIB_W(NIB_W)) u_tx (
    .clk(clk), .rst(rst), .raw_i(raw_eff),
    .nib_i(mac_tx_nib), .strobe_i(mac_tx_strobe), .fault_i(mac_tx_fault),
    .grp_o(line_tx_grp), .vld_o(line_tx_vld), .bad_o(line_tx_bad)
  );

  mii_rx_lane #(.NIB_W(NIB_W)) u_rx (
    .clk(clk), .rst(rst), .raw_i(raw_eff),
    .grp_i(line_rx_grp), .vld_i(line_rx_vld), .bad_i(line_rx_bad),
    .nib_o(mac_rx_nib), .strobe_o(mac_rx_strobe), .fault_o(mac_rx_fault)
  );

  mii_sense u_sense (
    .clk(clk), .rst(rst), .fdx_i(cur.fdx),
    .tx_live_i(mac_tx_strobe), .rx_live_i(line_rx_vld),
    .carrier_o(mac_carrier), .collide_o(mac_collide)
  );

  // R6: collision needs both directions active
  p_col_both_r6: assert property (@(posedge clk) disable iff (rst)
    mac_collide |-> (line_tx_vld && mac_rx_strobe));
  // R8: any activity raises carrier
  p_crs_rx_r8: assert property (@(posedge clk) disable iff (rst)
    mac_rx_strobe |-> mac_carrier);
  // R9: carrier without receive activity only in half duplex
  p_crs_fdx_r9: assert property (@(posedge clk) disable iff (rst)
    (mac_carrier && !mac_rx_strobe) |-> (line_tx_vld && !cur.fdx));
  // R11: outputs idle while in reset
  p_reset_idle_r11: assert property (@(posedge clk)
    $past(rst) |-> !(line_tx_vld || mac_rx_strobe || mac_carrier || mac_collide));
endmodule

// File: tb/mii_phy_port_test.sv
module mii_phy_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_fast = 1'b1, cfg_fdx = 1'b0, cfg_raw = 1'b0;
  logic [3:0] mac_tx_nib = '0;
  logic mac_tx_strobe = 1'b0, mac_tx_fault = 1'b0;
  logic [4:0] line_tx_grp;
  logic line_tx_vld, line_tx_bad;
  logic [4:0] line_rx_grp = '0;
  logic line_rx_vld = 1'b0, line_rx_bad = 1'b0;
  logic [3:0] mac_rx_nib;
  logic mac_rx_strobe, mac_rx_fault, mac_carrier, mac_collide;

  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mii_phy_port uut (.*);

  task automatic check(input logic [7:0] got, input logic [7:0] want, input string tag);
    n_run++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, want);
    end
  endtask

  task automatic drive(input logic te, input logic [3:0] tn, input logic tf,
                       input logic rv, input logic [4:0] rg, input logic rb);
    @(negedge clk);
    mac_tx_strobe = te; mac_tx_nib = tn; mac_tx_fault = tf;
    line_rx_vld = rv; line_rx_grp = rg; line_rx_bad = rb;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 4'h0, 1'b0, 1'b0, 5'h0, 1'b0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_bad++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    check({line_tx_grp, line_tx_vld, line_tx_bad, 1'b0}, 8'h0, "R11 tx");
    check({mac_rx_nib, mac_rx_strobe, mac_rx_fault, mac_carrier, mac_collide}, 8'h0, "R11 rx");
    @(negedge clk); rst = 1'b0;

    // Sweep all eight configurations and all input combinations
    for (int c = 0; c < 8; c++) begin
      idle(2);
      @(negedge clk);
      cfg_fast = c[0]; cfg_fdx = c[1]; cfg_raw = c[2];
      idle(2);
      for (int i = 0; i < 8192; i++) begin
        logic te, tf, rv, rb, byp, fd;
        logic [3:0] tn;
        logic [4:0] rg, xg;
        logic [3:0] xn;
        logic xb, xf;
        te = i[0]; tf = i[1]; tn = i[5:2];
        rv = i[6]; rb = i[7]; rg = i[12:8];
        byp = c[0] & c[2];
        fd = c[1];
        drive(te, tn, tf, rv, rg, rb);
        xg = te ? {byp & tf, tn} : 5'h0;
        xb = byp ? 1'b0 : (tf & te);
        xn = rv ? rg[3:0] : 4'h0;
        xf = byp ? (rg[4] & rv) : rb;
        // R1 R2 R5: transmit mapping
        check({line_tx_grp, line_tx_vld, line_tx_bad}, {xg, te, xb},
              byp ? "R2 tx raw" : (c[2] ? "R5 tx 10M" : "R1 tx"));
        // R3 R4 R5: receive mapping
        check({mac_rx_nib, mac_rx_strobe, mac_rx_fault}, {xn, rv, xf},
              byp ? "R4 rx raw" : (c[2] ? "R5 rx 10M" : "R3 rx"));
        // R8 R9: carrier
        check(mac_carrier, fd ? rv : (te | rv), fd ? "R9 crs" : "R8 crs");
        // R6 R7: collision
        check(mac_collide, (!fd) & te & rv, fd ? "R7 col" : "R6 col");
      end
    end

    // R10: mode change requested mid-frame waits for idle
    idle(2);
    @(negedge clk); cfg_fast = 1'b1; cfg_fdx = 1'b0; cfg_raw = 1'b0;
    idle(2);
    drive(1'b1, 4'h5, 1'b0, 1'b0, 5'h0, 1'b0);
    @(negedge clk); cfg_fdx = 1'b1; cfg_raw = 1'b1;
    drive(1'b1, 4'h6, 1'b1, 1'b1, 5'h13, 1'b0);
    check(mac_collide, 8'h1, "R10 col old duplex");
    check(line_tx_bad, 8'h1, "R10 tx old nibble mode");
    check(mac_rx_fault, 8'h0, "R10 rx old nibble mode");
    drive(1'b0, 4'h0, 1'b0, 1'b0, 5'h0, 1'b0);
    check(mac_carrier, 8'h0, "R10 carrier drops with activity");
    idle(2);
    drive(1'b1, 4'h6, 1'b1, 1'b1, 5'h13, 1'b0);
    check(mac_collide, 8'h0, "R10 col new duplex");
    check(line_tx_grp, 8'h16, "R10 tx new raw mode");
    check(mac_rx_fault, 8'h1, "R10 rx new raw mode");
    idle(1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule